// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits in the byte path of an MPEG transport stream. It checks the 13-bit packet identifier of every packet against a small table of up to 16 programmed values. When filtering is turned on, only packets whose identifier hits a programmed table entry come out. When filtering is off, every packet comes out. Each forwarded byte carries a 3-bit tag that names one of eight downstream buffers.

A microcontroller reaches the block through two registers. One is a control/status word. The other is a single table access port. Writes through the access port go to the entry named by a write pointer, and each write moves that pointer on by one. Reads through the port return the entry named by a separate read pointer, and each read moves that pointer on by one. Both pointers move only while filtering is off, so the table can be loaded and checked in order and then frozen.

Packet bytes are held in a three-byte pipeline. The forward-or-drop decision for a packet is made when its third byte arrives, which is the byte that completes the identifier. Because the first two bytes are still in the pipeline at that point, the whole packet is passed or dropped as one unit. A byte leaves the pipeline only when a newer byte enters, so output lags input by three accepted bytes.

Top module: `tspid_filter`

## Requirements
- R1: After reset the control/status word reads 0 (filter off, both pointers 0, buffer field 0) and out_valid is 0.
- R2: With the filter off, a write to the table port (reg_sel=1) stores reg_wdata[12:0] into the entry at the write pointer, marks it programmed and advances the write pointer by one, wrapping from 15 to 0. The write pointer is visible in status bits 11:8.
- R3: With reg_sel=1, reg_rdata returns the entry at the read pointer in bits 12:0, with zeros above. With the filter off, a read strobe then advances the read pointer by one, wrapping from 15 to 0. The read pointer is visible in status bits 15:12.
- R4: With the filter on, table-port reads leave the read pointer unchanged. Table-port writes change neither the table nor the write pointer.
- R5: A control write that sets bit 0 while the filter is off turns the filter on and sets the read pointer to 0.
- R6: A control write with bit 1 set clears every entry to 0, marks every entry unprogrammed and sets both pointers to 0. Bit 1 always reads as 0.
- R7: Status bits 31:16, 7 and 3:1 always read as 0, whatever was written to them. Bits 6:4 read back the buffer field and bit 0 reads back the enable.
- R8: With the filter off, every input byte comes out unchanged, with its start-of-packet flag, once three more bytes have been accepted. Output is registered, so it appears one edge after the byte that pushes it out.
- R9: With the filter on, the identifier is {byte1[4:0], byte2}, where byte0 is the byte flagged by in_sop and the top three bits of byte1 are ignored. A packet is forwarded whole if that value equals a programmed entry, and dropped whole otherwise.
- R10: out_buf carries status bits 6:4, as they stood at the edge that produced the output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the table port only) |
| reg_sel | input | 1 | 0 selects the control/status word, 1 selects the table access port |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first (sync) byte of a packet |
| in_data | input | 8 | Input stream byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is the first byte of a packet |
| out_data | output | 8 | Output stream byte |
| out_buf | output | 3 | Destination buffer index for the output byte |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each.

- A seventeenth write and read show whether the pointers wrap at 15. A design that does not wrap would carry a pointer into the wrong status bits.
- Table-port reads and writes while the filter is on show whether the pointers and table stay frozen. A design that does not freeze them would show a moved pointer or a changed entry.
- Enabling the filter with the read pointer at a non-zero value shows whether the enable forces it to 0.
- Streams with the top three bits of byte1 set show whether those bits are masked. A design that compares them would drop matching packets.
- Streams with identifier 0 after a table clear show whether cleared entries are treated as unprogrammed. A design that treats them as programmed would forward that packet.
- Reprogramming the buffer field in mid-stream shows whether the tag updates on the right byte. A design with a wrong decision point would split one packet between forwarding and dropping.

// File: rtl/tspid_filter.sv
module tspid_filter #(
  parameter int NENT  = 16,
  parameter int PID_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  output logic        out_sop,
  output logic [7:0]  out_data,
  output logic [2:0]  out_buf
);
  localparam int PW = $clog2(NENT);

  logic             en;
  logic [2:0]       wbuf;
  logic [PW-1:0]    rdp, wrp;
  logic [PID_W-1:0] tbl [NENT];
  logic [NENT-1:0]  used;

  wire csr_wr = reg_wr & ~reg_sel;
  wire tab_wr = reg_wr & reg_sel & ~en;
  wire tab_rd = reg_rd & reg_sel & ~en;
  wire clr    = csr_wr & reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      wbuf <= '0;
      rdp  <= '0;
      wrp  <= '0;
    end else begin
      if (csr_wr) begin
        en   <= reg_wdata[0];
        wbuf <= reg_wdata[6:4];
      end
      if (clr) begin
        rdp <= '0;
        wrp <= '0;
      end else begin
        if (tab_wr) wrp <= wrp + PW'(1);
        if (csr_wr & reg_wdata[0] & ~en) rdp <= '0;
        else if (tab_rd)                 rdp <= rdp + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
      used <= '0;
    end else if (clr) begin
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
      used <= '0;
    end else if (tab_wr) begin
      tbl[wrp]  <= reg_wdata[PID_W-1:0];
      used[wrp] <= 1'b1;
    end
  end

  assign reg_rdata = reg_sel ? 32'(tbl[rdp])
                             : {16'b0, 4'(rdp), 4'(wrp), 1'b0, wbuf, 3'b0, en};

  // byte index within packet: 0,1,2, then 3 meaning "past the identifier"
  logic [1:0]       idx;
  logic [4:0]       pid_hi;
  logic             pass, hit;
  logic [8:0]       p0, p1, p2;
  logic [2:0]       pv;
  wire  [1:0]       bi  = in_sop ? 2'd0 : idx;
  wire  [PID_W-1:0] pid = PID_W'({pid_hi, in_data});

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NENT; i++)
      if (used[i] && tbl[i] == pid) hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= 2'd3;
      pid_hi    <= '0;
      pass      <= 1'b0;
      p0        <= '0;
      p1        <= '0;
      p2        <= '0;
      pv        <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
      out_buf   <= '0;
    end else if (in_valid) begin
      p0        <= {in_sop, in_data};
      p1        <= p0;
      p2        <= p1;
      pv        <= {pv[1:0], 1'b1};
      idx       <= (bi == 2'd3) ? 2'd3 : bi + 2'd1;
      if (bi == 2'd1) pid_hi <= in_data[4:0];
      if (bi == 2'd2) pass   <= ~en | hit;
      out_valid <= pv[2] & pass;
      out_sop   <= p2[8];
      out_data  <= p2[7:0];
      out_buf   <= wbuf;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tspid_filter_chk.sv
module tspid_filter_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          reg_sel,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          en,
  input logic [PW-1:0] rdp,
  input logic [PW-1:0] wrp,
  input logic          in_valid,
  input logic          out_valid
);
  wire csr_wr = reg_wr & ~reg_sel;

  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !en) |=> (wrp == PW'($past(wrp) + PW'(1))));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reg_rd && reg_sel && !csr_wr) |=> $stable(rdp));

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !csr_wr) |=> $stable(wrp));

  p_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && reg_wdata[0] && !en) |=> (rdp == '0));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && reg_wdata[1]) |=> (rdp == '0 && wrp == '0));

  p_resv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[31:16] == 16'h0 && reg_rdata[7] == 1'b0 && reg_rdata[3:1] == 3'b0));

  p_out_needs_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

bind tspid_filter tspid_filter_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en(en), .rdp(rdp), .wrp(wrp),
  .in_valid(in_valid), .out_valid(out_valid)
);

// File: tb/tspid_filter_test.sv
module tspid_filter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        in_valid = 0, in_sop = 0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_sop;
  logic [7:0]  out_data;
  logic [2:0]  out_buf;

  always #2.5 clk = ~clk;

  tspid_filter uut (.*);

  int checks = 0, errors = 0;

  int   mtbl [16];
  bit   mused [16];
  int   mrd = 0, mwr = 0, mbuf = 0, midx = 3, mphi = 0;
  bit   men = 0, mpass = 0;
  bit [8:0] hq [$];
  bit   passq [$];
  bit   e_valid = 0, e_sop = 0;
  int   e_data = 0, e_buf = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int mcsr();
    return (mrd << 12) | (mwr << 8) | (mbuf << 4) | int'(men);
  endfunction

  task automatic step(string tag, bit wr, bit rd, bit sel, int wd, bit iv, bit isop, int idat);
    bit old_en;
    bit hit;
    int bi;
    bit [8:0] b;
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    in_valid = iv; in_sop = isop; in_data = idat[7:0];
    #1;
    chk(tag, reg_rdata, sel ? mtbl[mrd] : mcsr());
    @(posedge clk);
    old_en = men;
    e_valid = 0;
    if (iv) begin
      bi = isop ? 0 : midx;
      if (bi == 1) mphi = idat & 31;
      if (bi == 2) begin
        hit = 0;
        for (int i = 0; i < 16; i++)
          if (mused[i] && mtbl[i] == ((mphi << 8) | (idat & 255))) hit = 1;
        passq.push_back(!men || hit);
      end
      midx = (bi == 3) ? 3 : bi + 1;
      hq.push_back({isop, idat[7:0]});
      if (hq.size() > 3) begin
        b = hq.pop_front();
        if (b[8]) mpass = passq.pop_front();
        e_valid = mpass; e_sop = b[8]; e_data = b[7:0]; e_buf = mbuf;
      end
    end
    if (wr && !sel) begin
      if (wd[1]) begin
        for (int i = 0; i < 16; i++) begin mtbl[i] = 0; mused[i] = 0; end
        mrd = 0; mwr = 0;
      end else if (wd[0] && !old_en) mrd = 0;
      men = wd[0]; mbuf = (wd >> 4) & 7;
    end
    if (wr && sel && !old_en) begin
      mtbl[mwr] = wd & 32'h1FFF; mused[mwr] = 1; mwr = (mwr + 1) % 16;
    end
    if (rd && sel && !old_en) mrd = (mrd + 1) % 16;
    @(negedge clk);
    chk(tag, out_valid, e_valid);
    if (e_valid) begin
      chk(tag, out_data, e_data);
      chk(tag, out_sop, e_sop);
      chk(tag, out_buf, e_buf);
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pkt(string tag, int pid, int len, int hi);
    for (int i = 0; i < len; i++) begin
      int d;
      d = (i == 0) ? 8'h47 : (i == 1) ? ((hi << 5) | (pid >> 8)) : (i == 2) ? (pid & 255) : (i * 17 + pid) & 255;
      step(tag, 0, 0, 0, 0, 1, i == 0, d);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mtbl[i] = 0; mused[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    idle("R1");
    chk("R1", reg_rdata, 0);
    // R7: reserved bits ignored
    step("R7", 1, 0, 0, 32'hFFFF_FF8C, 0, 0, 0);
    idle("R7");
    chk("R7", reg_rdata, 0);
    // R2: seventeen writes wrap the write pointer
    for (int i = 0; i < 17; i++) step("R2", 1, 0, 1, 32'hFFFF_0000 | (i * 301 + 7), 0, 0, 0);
    idle("R2");
    chk("R2", reg_rdata[11:8], 1);
    // R3: seventeen reads wrap the read pointer
    for (int i = 0; i < 17; i++) step("R3", 0, 1, 1, 0, 0, 0, 0);
    idle("R3");
    chk("R3", reg_rdata[15:12], 1);
    // R8 + R10: filter off, everything passes tagged with buffer 5
    step("R10", 1, 0, 0, 32'h50, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      pkt("R8", k * 997 & 13'h1FFF, 3 + k % 4, k & 7);
      if (k == 2) idle("R8");
    end
    // R6: clear table and pointers
    step("R6", 1, 1, 1, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 32'h52, 0, 0, 0);
    idle("R6");
    chk("R6", reg_rdata, 32'h50);
    for (int i = 0; i < 16; i++) step("R6", 0, 1, 1, 0, 0, 0, 0);
    // program three identifiers
    step("R2", 1, 0, 1, 13'h1FFF, 0, 0, 0);
    step("R2", 1, 0, 1, 13'h0100, 0, 0, 0);
    step("R2", 1, 0, 1, 13'h00A5, 0, 0, 0);
    step("R3", 0, 1, 1, 0, 0, 0, 0);
    step("R3", 0, 1, 1, 0, 0, 0, 0);
    // R5: enabling forces read pointer to zero
    step("R5", 1, 0, 0, 32'h31, 0, 0, 0);
    idle("R5");
    chk("R5", reg_rdata[15:12], 0);
    chk("R5", reg_rdata[11:8], 3);
    // R4: pointers and table frozen while enabled
    for (int i = 0; i < 4; i++) step("R4", 1, 1, 1, 32'h0777, 0, 0, 0);
    step("R4", 0, 0, 1, 0, 0, 0, 0);
    chk("R4", reg_rdata, 32'h1FFF);
    idle("R4");
    chk("R4", reg_rdata, 32'h331);
    // R9: match decides whole packets; top bits of byte1 masked; zero is unprogrammed
    pkt("R9", 13'h0101, 5, 0);
    pkt("R9", 13'h1FFF, 4, 7);
    pkt("R9", 13'h0000, 4, 0);
    pkt("R9", 13'h00A5, 6, 5);
    pkt("R9", 13'h0100, 3, 2);
    pkt("R9", 13'h00A4, 4, 0);
    // R10: retag mid-stream while enabled
    step("R10", 1, 0, 0, 32'h61, 1, 1, 8'h47);
    step("R10", 0, 0, 0, 0, 1, 0, 8'h01);
    step("R10", 0, 0, 0, 0, 1, 0, 8'h00);
    step("R10", 1, 0, 0, 32'h21, 1, 0, 8'h33);
    pkt("R10", 13'h1FFF, 4, 1);
    pkt("R9", 13'h0005, 4, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule